// File: doc/BRIEF.md
# MDIO Single-Command Management Engine

This block lets software reach the management registers of an Ethernet PHY through a small register window. Software writes one command word that asks for either a read or a write, with a 5-bit PHY address and a 5-bit register number. The engine then sets a busy flag and sends one Clause 22 management frame on the MDC clock and the MDIO data line. When the last bit has been clocked, it clears the busy flag. Software polls the busy flag before it issues the next command.

For a write, software first loads the 16-bit value into the low half of the data register. For a read, the engine releases MDIO for the turnaround and shifts in the 16 data bits from the PHY. It then places the result in the upper half of the data register. If the PHY leaves MDIO high in the second turnaround bit, meaning it did not answer, the engine sets an invalid flag in a separate status register.

MDC comes from the system clock through a divider whose half period is `DIV_HALF` system clocks. The engine drives MDIO just after each falling MDC edge and samples it at each rising edge.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset, the command, data and status registers read 0, MDC is low and the MDIO output enable is low.
- R2: A write to the command register (offset 0x3C0) with bit 20 set and bit 17 (read) or bit 16 (write) set, while idle, starts a frame. Bit 20 reads 1 from the next clock until the frame ends, then reads 0. While busy, the command register reads back bit 17 and bit 16 as written, the PHY address in bits 12:8 and the register number in bits 4:0.
- R3: A command written while bit 20 reads 1 is ignored. The stored fields and the frame in progress are unchanged, and no second frame follows.
- R4: A write frame sends 64 bits, most significant first, all with the output enable high: 32 ones, start 01, opcode 01, the PHY address, the register number, turnaround 10, and then the 16 bits held in data register bits 15:0 (offset 0x3C4).
- R5: A read frame drives its first 46 bits the same way as a write frame, but with opcode 10. The output enable is then low for the 18 remaining bits.
- R6: At the end of a read, data register bits 31:16 hold the 16 MDIO values sampled at the rising MDC edges of the last 16 bits, first sample in bit 31. Bits 15:0 keep the value software wrote there.
- R7: At the end of a read, status register (offset 0x3D0) bit 0 is set to the MDIO level sampled in the second turnaround bit, so 1 means invalid. A write frame leaves this bit unchanged.
- R8: A command write with bit 20 clear, or with bit 20 set but neither bit 17 nor bit 16 set, starts nothing and does not change the stored command fields.
- R9: While busy, MDC has a period of 2*DIV_HALF system clocks. A frame has exactly 64 rising MDC edges. MDC is low whenever the engine is idle.
- R10: A read from any offset other than the three registers returns 0.
- R11: When bits 17 and 16 are both set, the frame is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the engine |
| mdio_oe | output | 1 | MDIO output enable, high while the engine drives the line |
| mdio_i | input | 1 | MDIO level seen on the pad |

## Verification
The bench builds the engine with `DIV_HALF` = 2 and keeps the default 12-bit offset width. This makes one frame only 256 system clocks long, so many randomly chosen reads and writes fit in a short run. It also puts the period check and the turnaround timing on exact, small cycle counts. The responder in the bench can answer or stay silent. That reaches both states of the invalid flag and the all-ones data that a pulled-up line gives when no PHY answers.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;

  localparam int FIELD_W     = 5;
  localparam int FRAME_BITS  = 64;
  localparam int DRIVEN_RD   = 46;
  localparam int TA2_INDEX   = 47;
  localparam int DATA_FIRST  = 48;
  localparam int BITCNT_W    = $clog2(FRAME_BITS);

  localparam int BUSY_BIT    = 20;
  localparam int RD_BIT      = 17;
  localparam int WR_BIT      = 16;
  localparam int PHY_LSB     = 8;
  localparam int REG_LSB     = 0;

  localparam logic [11:0] OFS_CMD  = 12'h3C0;
  localparam logic [11:0] OFS_DATA = 12'h3C4;
  localparam logic [11:0] OFS_STAT = 12'h3D0;

  typedef struct packed {
    logic               is_read;
    logic               rd_req;
    logic               wr_req;
    logic [FIELD_W-1:0] phy;
    logic [FIELD_W-1:0] regn;
  } mdio_cmd_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic               rd,
    input logic [FIELD_W-1:0] phy,
    input logic [FIELD_W-1:0] regn,
    input logic [15:0]        wval
  );
    logic [1:0]  opc;
    logic [1:0]  ta;
    logic [15:0] dat;
    opc = rd ? 2'b10 : 2'b01;
    ta  = rd ? 2'b11 : 2'b10;
    dat = rd ? 16'hFFFF : wval;
    return {32'hFFFF_FFFF, 2'b01, opc, phy, regn, ta, dat};
  endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_HALF = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);

  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          terminal;

  assign terminal = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (terminal) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = terminal & ~mdc_q;
  assign fall_tick = terminal &  mdc_q;

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_eng_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic [15:0] wr_value,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rd_result,
  output logic        rd_invalid
);

  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(FRAME_BITS - 1);
  localparam logic [BITCNT_W-1:0] TA2_BIT  = BITCNT_W'(TA2_INDEX);
  localparam logic [BITCNT_W-1:0] DAT_BIT  = BITCNT_W'(DATA_FIRST);
  localparam logic [BITCNT_W-1:0] DRV_END  = BITCNT_W'(DRIVEN_RD);

  logic                  busy_q, busy_d;
  logic [BITCNT_W-1:0]   bit_q, bit_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  rd_q, rd_d;
  logic [15:0]           in_q, in_d;
  logic                  ta_q, ta_d;
  logic [15:0]           res_q, res_d;
  logic                  inv_q, inv_d;
  logic                  last_fall;

  assign last_fall = busy_q && fall_tick && (bit_q == LAST_BIT);

  always_comb begin
    busy_d = busy_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rd_d   = rd_q;
    in_d   = in_q;
    ta_d   = ta_q;
    res_d  = res_q;
    inv_d  = inv_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      bit_d  = '0;
      sh_d   = build_frame(cmd.is_read, cmd.phy, cmd.regn, wr_value);
      rd_d   = cmd.is_read;
    end else if (busy_q) begin
      if (rise_tick && rd_q) begin
        if (bit_q == TA2_BIT) ta_d = mdio_i;
        if (bit_q >= DAT_BIT) in_d = {in_q[14:0], mdio_i};
      end
      if (fall_tick) begin
        if (last_fall) begin
          busy_d = 1'b0;
          if (rd_q) begin
            res_d = in_q;
            inv_d = ta_q;
          end
        end else begin
          bit_d = bit_q + 1'b1;
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
      rd_q   <= 1'b0;
      in_q   <= '0;
      ta_q   <= 1'b0;
      res_q  <= '0;
      inv_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rd_q   <= rd_d;
      in_q   <= in_d;
      ta_q   <= ta_d;
      res_q  <= res_d;
      inv_q  <= inv_d;
    end
  end

  assign busy       = busy_q;
  assign mdio_o     = sh_q[FRAME_BITS-1];
  assign mdio_oe    = busy_q && (!rd_q || (bit_q < DRV_END));
  assign rd_result  = res_q;
  assign rd_invalid = inv_q;

endmodule

// File: rtl/mdio_reg_if.sv
module mdio_reg_if
  import mdio_eng_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              busy,
  input  logic [15:0]       rd_result,
  input  logic              rd_invalid,
  output logic              start,
  output mdio_cmd_t         cmd,
  output logic [15:0]       wr_value,
  output logic [31:0]       reg_rdata
);

  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  mdio_cmd_t   cmd_q, cmd_d;
  logic [15:0] wv_q, wv_d;
  logic        cmd_hit, data_hit, accept;

  assign cmd_hit  = reg_wr && (reg_addr == A_CMD);
  assign data_hit = reg_wr && (reg_addr == A_DATA);
  assign accept   = cmd_hit && !busy && reg_wdata[BUSY_BIT] &&
                    (reg_wdata[RD_BIT] || reg_wdata[WR_BIT]);

  always_comb begin
    cmd_d = cmd_q;
    wv_d  = wv_q;
    if (accept) begin
      cmd_d.is_read = reg_wdata[RD_BIT];
      cmd_d.rd_req  = reg_wdata[RD_BIT];
      cmd_d.wr_req  = reg_wdata[WR_BIT];
      cmd_d.phy     = reg_wdata[PHY_LSB +: FIELD_W];
      cmd_d.regn    = reg_wdata[REG_LSB +: FIELD_W];
    end
    if (data_hit) wv_d = reg_wdata[15:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      wv_q  <= '0;
    end else begin
      cmd_q <= cmd_d;
      wv_q  <= wv_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CMD) begin
      reg_rdata[BUSY_BIT]                = busy;
      reg_rdata[RD_BIT]                  = cmd_q.rd_req;
      reg_rdata[WR_BIT]                  = cmd_q.wr_req;
      reg_rdata[PHY_LSB +: FIELD_W]      = cmd_q.phy;
      reg_rdata[REG_LSB +: FIELD_W]      = cmd_q.regn;
    end else if (reg_addr == A_DATA) begin
      reg_rdata = {rd_result, wv_q};
    end else if (reg_addr == A_STAT) begin
      reg_rdata[0] = rd_invalid;
    end
  end

  assign start    = accept;
  assign cmd      = cmd_d;
  assign wr_value = wv_q;

endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_eng_pkg::*;
#(
  parameter int DIV_HALF = 10,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  logic        eng_busy;
  logic        start;
  mdio_cmd_t   next_cmd;
  logic [15:0] wr_value;
  logic [15:0] rd_result;
  logic        rd_invalid;
  logic        rise_tick, fall_tick;

  mdio_reg_if #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .busy       (eng_busy),
    .rd_result  (rd_result),
    .rd_invalid (rd_invalid),
    .start      (start),
    .cmd        (next_cmd),
    .wr_value   (wr_value),
    .reg_rdata  (reg_rdata)
  );

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (eng_busy),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_engine u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cmd        (next_cmd),
    .wr_value   (wr_value),
    .rise_tick  (rise_tick),
    .fall_tick  (fall_tick),
    .mdio_i     (mdio_i),
    .busy       (eng_busy),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .rd_result  (rd_result),
    .rd_invalid (rd_invalid)
  );

endmodule

// File: rtl/mdio_eng_checker.sv
module mdio_eng_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              busy,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic [10:0]       cmd_fields,
  input logic              cur_read,
  input logic              rd_invalid
);

  logic cmd_wr;
  assign cmd_wr = reg_wr && (reg_addr == ADDR_W'(12'h3C0));

  AST_BUSY_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && reg_wdata[20] && (reg_wdata[17] || reg_wdata[16])) |=> busy); // R2

  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> $stable(cmd_fields)); // R3

  AST_NO_START_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && !reg_wdata[20]) |=> !busy); // R8

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R9

  AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe); // R4

  AST_DATA_STABLE_HIGH_MDC: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && mdc && $past(mdc)) |-> $stable(mdio_o)); // R4

  AST_WRITE_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cur_read) |=> $stable(rd_invalid)); // R7

endmodule

bind mdio_cmd_engine mdio_eng_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .busy       (eng_busy),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .cmd_fields ({u_regs.cmd_q.rd_req, u_regs.cmd_q.wr_req, u_regs.cmd_q.phy, u_regs.cmd_q.regn[4:2], u_regs.cmd_q.regn[1:0]}),
  .cur_read   (u_regs.cmd_q.is_read),
  .rd_invalid (rd_invalid)
);

// File: tb/mdio_cmd_engine_test.sv
`timescale 1ns/1ps
module mdio_cmd_engine_test;

  localparam int DIVH   = 2;
  localparam int AW     = 12;
  localparam logic [11:0] A_CMD  = 12'h3C0;
  localparam logic [11:0] A_DATA = 12'h3C4;
  localparam logic [11:0] A_STAT = 12'h3D0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // PHY responder state
  logic [15:0] resp_val = '0;
  logic        resp_present = 1'b1;
  int          drv_idx = 0;
  int          cap_idx = 0;
  logic [63:0] cap_d = '0;
  logic [63:0] cap_oe = '0;
  int          last_rise = 0;
  int          mdc_period = 0;

  // expected software-visible state
  logic [15:0] exp_lo = '0;
  logic [15:0] exp_hi = '0;
  logic        exp_inv = 1'b0;
  logic        f_rd = 1'b0, f_rdb = 1'b0, f_wrb = 1'b0;
  logic [4:0]  f_phy = '0, f_reg = '0;
  logic [15:0] f_val = '0;

  mdio_cmd_engine #(.DIV_HALF(DIVH), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #4 clk = ~clk;

  function automatic logic phy_level(input int k);
    if (k == 47) return resp_present ? 1'b0 : 1'b1;
    if (k >= 48 && k <= 63) return resp_present ? resp_val[63-k] : 1'b1;
    return 1'b1;
  endfunction

  assign mdio_i = mdio_oe ? mdio_o : phy_level(drv_idx);

  always @(negedge mdc) drv_idx = drv_idx + 1;

  always @(posedge mdc) begin
    if (cap_idx < 64) begin
      cap_d[63-cap_idx]  = mdio_o;
      cap_oe[63-cap_idx] = mdio_oe;
    end
    cap_idx    = cap_idx + 1;
    mdc_period = cyc - last_rise;
    last_rise  = cyc;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL R2 watchdog: cycles %0d expected below %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] v);
    logic [63:0] f;
    f[63:32] = 32'hFFFF_FFFF;
    f[31:30] = 2'b01;
    f[29:28] = rd ? 2'b10 : 2'b01;
    f[27:23] = p;
    f[22:18] = r;
    f[17:16] = 2'b10;
    f[15:0]  = v;
    return f;
  endfunction

  function automatic logic [63:0] exp_oe_mask(input logic rd);
    return rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
  endfunction

  function automatic logic [31:0] cmd_word(input logic b, input logic rb, input logic wb,
                                           input logic [4:0] p, input logic [4:0] r);
    logic [31:0] w;
    w = '0; w[20] = b; w[17] = rb; w[16] = wb; w[12:8] = p; w[4:0] = r;
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic start_op(input logic rdb, input logic wrb, input logic [4:0] p,
                          input logic [4:0] r, input logic [15:0] v, input logic pres);
    logic [31:0] rv;
    f_rd = rdb; f_rdb = rdb; f_wrb = wrb; f_phy = p; f_reg = r; f_val = v;
    if (!rdb) begin
      reg_write(A_DATA, {16'hA5A5, v});
      exp_lo = v;
    end
    resp_val = v; resp_present = pres;
    drv_idx = 0; cap_idx = 0; cap_d = '0; cap_oe = '0;
    reg_write(A_CMD, cmd_word(1'b1, rdb, wrb, p, r));
    reg_read(A_CMD, rv);
    check(rv == cmd_word(1'b1, rdb, wrb, p, r), "R2 busy and fields after start", rv, cmd_word(1'b1, rdb, wrb, p, r));
  endtask

  task automatic finish_op();
    logic [31:0] rv;
    logic [63:0] ef, em;
    int n;
    n = 0;
    reg_read(A_CMD, rv);
    while (rv[20] && n < 2000) begin
      @(negedge clk);
      reg_read(A_CMD, rv);
      n++;
    end
    check(rv[20] == 1'b0, "R2 busy clears", rv[20], 0);
    check(cap_idx == 64, "R9 rising edges per frame", cap_idx, 64);
    em = exp_oe_mask(f_rd);
    ef = exp_frame(f_rd, f_phy, f_reg, f_val);
    if (f_rd) begin
      check(cap_oe == em, "R5 read output enable pattern", cap_oe, em);
      check((cap_d & em) == (ef & em), "R5 read frame header", cap_d & em, ef & em);
      exp_hi  = resp_present ? resp_val : 16'hFFFF;
      exp_inv = !resp_present;
      reg_read(A_DATA, rv);
      check(rv[31:16] == exp_hi, "R6 read data upper half", rv[31:16], exp_hi);
      check(rv[15:0] == exp_lo, "R6 lower half kept", rv[15:0], exp_lo);
    end else begin
      check(cap_oe == em, "R4 write output enable", cap_oe, em);
      check(cap_d == ef, "R4 write frame bits", cap_d, ef);
    end
    reg_read(A_STAT, rv);
    check(rv == {31'b0, exp_inv}, "R7 status invalid bit", rv, exp_inv);
    check(mdc == 1'b0, "R9 mdc low when idle", mdc, 0);
  endtask

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    reg_read(A_CMD, rv);  check(rv == 0, "R1 command after reset", rv, 0);
    reg_read(A_DATA, rv); check(rv == 0, "R1 data after reset", rv, 0);
    reg_read(A_STAT, rv); check(rv == 0, "R1 status after reset", rv, 0);
    check(mdc == 0 && mdio_oe == 0, "R1 mdc and enable low", {mdc, mdio_oe}, 0);

    // R10 unmapped offset
    reg_read(12'h3C8, rv); check(rv == 0, "R10 unmapped read", rv, 0);
    reg_read(12'h000, rv); check(rv == 0, "R10 unmapped read zero offset", rv, 0);

    // directed write, read with and without a PHY
    start_op(1'b0, 1'b1, 5'h1F, 5'h00, 16'hFFFF, 1'b1); finish_op();
    check(mdc_period == 2*DIVH, "R9 mdc period", mdc_period, 2*DIVH);
    start_op(1'b1, 1'b0, 5'h00, 5'h1F, 16'h0000, 1'b1); finish_op();
    start_op(1'b1, 1'b0, 5'h03, 5'h02, 16'h8001, 1'b0); finish_op();
    start_op(1'b0, 1'b1, 5'h05, 5'h09, 16'h1234, 1'b1); finish_op(); // R7 write keeps invalid

    // R11 both op bits set -> read
    start_op(1'b1, 1'b1, 5'h0A, 5'h15, 16'hC3C3, 1'b1); finish_op();

    // R8 no start bit, and start bit with no op bit
    reg_write(A_CMD, cmd_word(1'b0, 1'b1, 1'b0, 5'h11, 5'h11));
    @(negedge clk);
    reg_read(A_CMD, rv);
    check(rv == cmd_word(1'b0, 1'b1, 1'b1, 5'h0A, 5'h15), "R8 write without start bit", rv, cmd_word(1'b0, 1'b1, 1'b1, 5'h0A, 5'h15));
    check(mdc == 0, "R8 no clock without start", mdc, 0);
    reg_write(A_CMD, cmd_word(1'b1, 1'b0, 1'b0, 5'h12, 5'h13));
    @(negedge clk);
    reg_read(A_CMD, rv);
    check(rv == cmd_word(1'b0, 1'b1, 1'b1, 5'h0A, 5'h15), "R8 start bit without op", rv, cmd_word(1'b0, 1'b1, 1'b1, 5'h0A, 5'h15));

    // R3 command while busy is ignored
    start_op(1'b0, 1'b1, 5'h07, 5'h0C, 16'h5AA5, 1'b1);
    repeat (40) @(negedge clk);
    reg_write(A_CMD, cmd_word(1'b1, 1'b1, 1'b0, 5'h19, 5'h06));
    reg_read(A_CMD, rv);
    check(rv == cmd_word(1'b1, 1'b0, 1'b1, 5'h07, 5'h0C), "R3 fields kept while busy", rv, cmd_word(1'b1, 1'b0, 1'b1, 5'h07, 5'h0C));
    finish_op();
    repeat (20) @(negedge clk);
    check(cap_idx == 64, "R3 no second frame", cap_idx, 64);

    // random mix
    begin
      int seed;
      logic [31:0] r;
      seed = 32'h2024;
      r = $urandom(seed);
      for (int i = 0; i < 24; i++) begin
        logic rd, pr;
        r  = $urandom;
        rd = r[0];
        pr = (r[3:1] != 3'd0);
        start_op(rd, !rd, r[8:4], r[13:9], r[29:14], pr);
        finish_op();
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule